// File: doc/BRIEF.md
# Character LCD 4-bit Bus Controller

This block drives a character display controller over a 4-bit parallel bus with a register-select line, a read/write line and an enable strobe. Every byte crosses the bus as two nibble transfers, upper nibble first. The enable pulse width and the quiet gap after each nibble come from a single delay counter. One parameter, the number of clock ticks per microsecond, scales that counter, so the bus timing stays the same at any system clock.

After reset the block waits for the display to power up. It then sends the wake-up nibbles, each followed by its own wait, which switch the display into 4-bit mode. It finishes with a fixed list of setup commands. Only after that list is done does it offer ready to its client. The client then issues one request at a time on a valid/ready handshake:
- a command write,
- a character write,
- a status read,
- a character read.

Reads return the combined byte on a one-cycle response strobe. The clear and home commands are followed by long waits, and ready stays low during those waits.

Top module: `lcd_nibble_bus`

## Requirements
- R1: After reset, reqReady and initDone are low and the enable line stays low for the power-up wait of POWER_US microseconds; initDone, once set, stays set.
- R2: The start-up sequence places these nibbles on the bus in order, all with select low and read/write low: 0x3, 0x3, 0x3, 0x2, then the bytes 0x28, 0x08, 0x01, 0x06, 0x0C, each as a pair of nibbles.
- R3: The interval from one enable falling edge to the next during start-up is 4100 us plus one pulse after the first wake-up nibble, 100 us plus one pulse after the second, and 40 us plus one pulse after the third and fourth.
- R4: Each byte goes out as two transfers, with bits 7..4 first and bits 3..0 second. Enable is high for exactly TICKS_PER_US cycles per transfer, and the data, select and read/write lines do not change while enable is high.
- R5: Enable does not rise again until GAP_US (40 us) after the previous falling edge, so consecutive falls inside a byte and between bytes are GAP_US plus one pulse apart.
- R6: A command write of 0x01 (clear) holds reqReady low, and keeps the bus quiet, for CLEAR_US (2000 us) after its second nibble.
- R7: A command write of 0x02 (home) holds reqReady low for HOME_US (1600 us) after its second nibble.
- R8: The select line is low for command writes and status reads (reqIsData = 0) and high for character writes and reads (reqIsData = 1).
- R9: On a read (reqIsRead = 1) the read/write line is high and lcdDataOe is low. The input nibble is sampled at each enable fall, and rspValid pulses for one cycle at the second fall with rspByte = first nibble * 16 + second nibble.
- R10: A request is taken only when reqReady is high, and reqReady is high only when the block is idle and start-up is complete. A request held while reqReady is low produces no transfer.
- R11: After an ordinary write or read, reqReady returns exactly 2 * (TICKS_PER_US + GAP_US * TICKS_PER_US) cycles after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block idle and initialized; request taken when both high |
| reqIsData | input | 1 | 1 selects character data, 0 selects command/status |
| reqIsRead | input | 1 | 1 for a read, 0 for a write |
| reqByte | input | 8 | Byte to write (ignored for reads) |
| rspValid | output | 1 | One-cycle strobe: read byte available |
| rspByte | output | 8 | Byte assembled from the two read nibbles |
| initDone | output | 1 | Start-up sequence finished |
| lcdRs | output | 1 | Register-select line |
| lcdRw | output | 1 | Read/write line (1 = read) |
| lcdEn | output | 1 | Enable strobe |
| lcdDataOut | output | 4 | Nibble driven onto the bus |
| lcdDataOe | output | 1 | Output enable for the nibble bus |
| lcdDataIn | input | 4 | Nibble read from the bus |

## Verification
With one tick per microsecond, an accepted request raises enable on the accepting edge and drops it one cycle later. The second nibble falls 41 cycles after the first. Ready comes back 82 cycles after acceptance, or 2042 and 1642 cycles for clear and home, and the read response appears in the same cycle as the second enable fall. The bench timestamps every enable fall on the falling clock edge and compares differences between timestamps, not absolute times, against these figures. The one absolute check is the first fall after reset, which is due on edge POWER_US + 1. Ready-low intervals are counted one falling clock edge at a time from the acceptance edge onward.

// File: rtl/lcd_nibble_pkg.sv
package lcd_nibble_pkg;

  typedef enum logic [2:0] {
    DLY_PULSE, DLY_GAP, DLY_WAKE1, DLY_WAKE2, DLY_CLEAR, DLY_HOME, DLY_POWER
  } dlySel_e;

  typedef enum logic [1:0] {C_PWAIT, C_PULSE, C_GAP, C_IDLE} ctlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       load;
    logic [7:0] loadByte;
    logic       loadRs;
    logic       loadRw;
    logic       nibLow;
    logic       enSet;
    logic       enClr;
    logic       startWait;
    dlySel_e    dly;
  } lcdStrobe_t;

  typedef struct packed {
    logic       single;
    logic [7:0] value;
    dlySel_e    post;
  } initItem_t;

  localparam int INIT_LEN = 9;
  localparam logic [7:0] CMD_CLEAR = 8'h01;
  localparam logic [7:0] CMD_HOME  = 8'h02;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // wait that follows the second nibble of a byte
  function automatic dlySel_e postWait(input logic isData, input logic isRead,
                                       input logic [7:0] b);
    if (!isData && !isRead && b == CMD_CLEAR) return DLY_CLEAR;
    if (!isData && !isRead && b == CMD_HOME)  return DLY_HOME;
    return DLY_GAP;
  endfunction

  // start-up list: wake-up nibbles sit in bits 7..4
  function automatic initItem_t initItem(input logic [3:0] idx);
    initItem_t it;
    it.single = 1'b0;
    it.value  = 8'h00;
    it.post   = DLY_GAP;
    case (idx)
      4'd0: begin it.single = 1'b1; it.value = 8'h30; it.post = DLY_WAKE1; end
      4'd1: begin it.single = 1'b1; it.value = 8'h30; it.post = DLY_WAKE2; end
      4'd2: begin it.single = 1'b1; it.value = 8'h30; end
      4'd3: begin it.single = 1'b1; it.value = 8'h20; end
      4'd4: it.value = 8'h28;
      4'd5: it.value = 8'h08;
      4'd6: begin it.value = 8'h01; it.post = postWait(1'b0, 1'b0, 8'h01); end
      4'd7: it.value = 8'h06;
      default: it.value = 8'h0C;
    endcase
    return it;
  endfunction

endpackage

// File: rtl/lcd_nibble_dp.sv
module lcd_nibble_dp
  import lcd_nibble_pkg::*;
#(
  parameter int TICKS_PER_US = 50,
  parameter int POWER_US     = 20000,
  parameter int WAKE1_US     = 4100,
  parameter int WAKE2_US     = 100,
  parameter int GAP_US       = 40,
  parameter int CLEAR_US     = 2000,
  parameter int HOME_US      = 1600
) (
  input  logic       clk,
  input  logic       rstN,
  input  lcdStrobe_t strobe,
  input  logic [3:0] lcdDataIn,
  output logic       delayDone,
  output logic       lcdRs,
  output logic       lcdRw,
  output logic       lcdEn,
  output logic [3:0] lcdDataOut,
  output logic       lcdDataOe,
  output logic       rspValid,
  output logic [7:0] rspByte
);

  localparam int PULSE_CYC = TICKS_PER_US;
  localparam int GAP_CYC   = GAP_US * TICKS_PER_US;
  localparam int WAKE1_CYC = WAKE1_US * TICKS_PER_US;
  localparam int WAKE2_CYC = WAKE2_US * TICKS_PER_US;
  localparam int CLEAR_CYC = CLEAR_US * TICKS_PER_US;
  localparam int HOME_CYC  = HOME_US * TICKS_PER_US;
  localparam int POWER_CYC = POWER_US * TICKS_PER_US;
  localparam int MAX_CYC   = maxOf(maxOf(POWER_CYC, WAKE1_CYC),
                                   maxOf(CLEAR_CYC, HOME_CYC));
  localparam int CNT_W     = $clog2(MAX_CYC + 1);

  logic [7:0]       byteReg;
  logic             rsReg, rwReg, nibLowR, enReg, rspValidR;
  logic [3:0]       hiCap;
  logic [7:0]       rspByteR;
  logic [CNT_W-1:0] delayCnt, waitLoad;

  always_comb begin
    case (strobe.dly)
      DLY_PULSE: waitLoad = CNT_W'(PULSE_CYC - 1);
      DLY_GAP:   waitLoad = CNT_W'(GAP_CYC - 1);
      DLY_WAKE1: waitLoad = CNT_W'(WAKE1_CYC - 1);
      DLY_WAKE2: waitLoad = CNT_W'(WAKE2_CYC - 1);
      DLY_CLEAR: waitLoad = CNT_W'(CLEAR_CYC - 1);
      DLY_HOME:  waitLoad = CNT_W'(HOME_CYC - 1);
      default:   waitLoad = CNT_W'(POWER_CYC - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteReg   <= '0;
      rsReg     <= 1'b0;
      rwReg     <= 1'b0;
      nibLowR   <= 1'b0;
      enReg     <= 1'b0;
      hiCap     <= '0;
      rspByteR  <= '0;
      rspValidR <= 1'b0;
      delayCnt  <= CNT_W'(POWER_CYC - 1);
    end else begin
      rspValidR <= 1'b0;
      if (strobe.load) begin
        byteReg <= strobe.loadByte;
        rsReg   <= strobe.loadRs;
        rwReg   <= strobe.loadRw;
        nibLowR <= 1'b0;
      end
      if (strobe.nibLow) nibLowR <= 1'b1;
      if (strobe.enSet) begin
        enReg <= 1'b1;
      end else if (strobe.enClr) begin
        enReg <= 1'b0;
        if (rwReg) begin
          if (!nibLowR) begin
            hiCap <= lcdDataIn;
          end else begin
            rspByteR  <= {hiCap, lcdDataIn};
            rspValidR <= 1'b1;
          end
        end
      end
      if (strobe.startWait)     delayCnt <= waitLoad;
      else if (delayCnt != '0)  delayCnt <= delayCnt - 1'b1;
    end
  end

  assign delayDone  = (delayCnt == '0);
  assign lcdRs      = rsReg;
  assign lcdRw      = rwReg;
  assign lcdEn      = enReg;
  assign lcdDataOut = nibLowR ? byteReg[3:0] : byteReg[7:4];
  assign lcdDataOe  = !rwReg;
  assign rspValid   = rspValidR;
  assign rspByte    = rspByteR;

  AST_EN_HOLDS_BUS: assert property (@(posedge clk) disable iff (!rstN)
    enReg && $past(enReg) |-> $stable(lcdDataOut) && $stable(rsReg) && $stable(rwReg)); // R4

  AST_RSP_AT_FALL: assert property (@(posedge clk) disable iff (!rstN)
    rspValidR |-> $past(enReg) && !enReg && rwReg); // R9

endmodule

// File: rtl/lcd_nibble_fsm.sv
module lcd_nibble_fsm
  import lcd_nibble_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqIsData,
  input  logic       reqIsRead,
  input  logic [7:0] reqByte,
  input  logic       delayDone,
  output logic       reqReady,
  output logic       initDone,
  output lcdStrobe_t strobe
);

  ctlState_e state, nState;
  logic [3:0] initIdx, nIdx;
  logic       singleR, nSingle, lowR, nLow, initDoneR, nDone, launchInit;
  dlySel_e    postR, nPost;
  initItem_t  item;

  always_comb begin
    strobe.load      = 1'b0;
    strobe.loadByte  = 8'h00;
    strobe.loadRs    = 1'b0;
    strobe.loadRw    = 1'b0;
    strobe.nibLow    = 1'b0;
    strobe.enSet     = 1'b0;
    strobe.enClr     = 1'b0;
    strobe.startWait = 1'b0;
    strobe.dly       = DLY_PULSE;
    nState     = state;
    nIdx       = initIdx;
    nSingle    = singleR;
    nLow       = lowR;
    nPost      = postR;
    nDone      = initDoneR;
    launchInit = 1'b0;
    item       = initItem(initIdx);

    case (state)
      C_PWAIT: if (delayDone) launchInit = 1'b1;
      C_PULSE: if (delayDone) begin
        strobe.enClr     = 1'b1;
        strobe.startWait = 1'b1;
        strobe.dly       = (singleR || lowR) ? postR : DLY_GAP;
        nState           = C_GAP;
      end
      C_GAP: if (delayDone) begin
        if (!singleR && !lowR) begin
          strobe.nibLow    = 1'b1;
          strobe.enSet     = 1'b1;
          strobe.startWait = 1'b1;
          strobe.dly       = DLY_PULSE;
          nLow             = 1'b1;
          nState           = C_PULSE;
        end else if (initDoneR) begin
          nState = C_IDLE;
        end else if (initIdx == 4'(INIT_LEN)) begin
          nDone  = 1'b1;
          nState = C_IDLE;
        end else begin
          launchInit = 1'b1;
        end
      end
      C_IDLE: if (reqValid) begin
        strobe.load      = 1'b1;
        strobe.loadByte  = reqByte;
        strobe.loadRs    = reqIsData;
        strobe.loadRw    = reqIsRead;
        strobe.enSet     = 1'b1;
        strobe.startWait = 1'b1;
        strobe.dly       = DLY_PULSE;
        nSingle          = 1'b0;
        nLow             = 1'b0;
        nPost            = postWait(reqIsData, reqIsRead, reqByte);
        nState           = C_PULSE;
      end
      default: nState = C_IDLE;
    endcase

    if (launchInit) begin
      strobe.load      = 1'b1;
      strobe.loadByte  = item.value;
      strobe.enSet     = 1'b1;
      strobe.startWait = 1'b1;
      strobe.dly       = DLY_PULSE;
      nSingle          = item.single;
      nLow             = 1'b0;
      nPost            = item.post;
      nIdx             = initIdx + 4'd1;
      nState           = C_PULSE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= C_PWAIT;
      initIdx   <= '0;
      singleR   <= 1'b0;
      lowR      <= 1'b0;
      postR     <= DLY_GAP;
      initDoneR <= 1'b0;
    end else begin
      state     <= nState;
      initIdx   <= nIdx;
      singleR   <= nSingle;
      lowR      <= nLow;
      postR     <= nPost;
      initDoneR <= nDone;
    end
  end

  assign reqReady = (state == C_IDLE);
  assign initDone = initDoneR;

  AST_READY_AFTER_INIT: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> initDoneR); // R10

  AST_INIT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    initDoneR |=> initDoneR); // R1

endmodule

// File: rtl/lcd_nibble_bus.sv
module lcd_nibble_bus
  import lcd_nibble_pkg::*;
#(
  parameter int TICKS_PER_US = 50,
  parameter int POWER_US     = 20000,
  parameter int WAKE1_US     = 4100,
  parameter int WAKE2_US     = 100,
  parameter int GAP_US       = 40,
  parameter int CLEAR_US     = 2000,
  parameter int HOME_US      = 1600
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output logic       reqReady,
  input  logic       reqIsData,
  input  logic       reqIsRead,
  input  logic [7:0] reqByte,
  output logic       rspValid,
  output logic [7:0] rspByte,
  output logic       initDone,
  output logic       lcdRs,
  output logic       lcdRw,
  output logic       lcdEn,
  output logic [3:0] lcdDataOut,
  output logic       lcdDataOe,
  input  logic [3:0] lcdDataIn
);

  lcdStrobe_t strobe;
  logic       delayDone;

  lcd_nibble_fsm u_fsm (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqIsData(reqIsData),
    .reqIsRead(reqIsRead), .reqByte(reqByte), .delayDone(delayDone),
    .reqReady(reqReady), .initDone(initDone), .strobe(strobe)
  );

  lcd_nibble_dp #(
    .TICKS_PER_US(TICKS_PER_US), .POWER_US(POWER_US), .WAKE1_US(WAKE1_US),
    .WAKE2_US(WAKE2_US), .GAP_US(GAP_US), .CLEAR_US(CLEAR_US), .HOME_US(HOME_US)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .lcdDataIn(lcdDataIn),
    .delayDone(delayDone), .lcdRs(lcdRs), .lcdRw(lcdRw), .lcdEn(lcdEn),
    .lcdDataOut(lcdDataOut), .lcdDataOe(lcdDataOe), .rspValid(rspValid),
    .rspByte(rspByte)
  );

  AST_EN_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    lcdEn |-> !reqReady); // R10

  AST_ACCEPT_RAISES_EN: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> lcdEn); // R4

endmodule

// File: tb/lcd_nibble_bus_bench.sv
`timescale 1ns/100ps
module lcd_nibble_bus_bench;

  localparam int T = 1;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0, reqIsData = 1'b0, reqIsRead = 1'b0;
  logic [7:0] reqByte = 8'h00;
  logic       reqReady, rspValid, initDone, lcdRs, lcdRw, lcdEn, lcdDataOe;
  logic [7:0] rspByte;
  logic [3:0] lcdDataOut, lcdDataIn;
  logic [3:0] rdHi = 4'h0, rdLo = 4'h0;
  logic       rdPhase = 1'b0;

  int checks = 0, errors = 0;
  int cyc = 0, nEv = 0, width = 0, stabErr = 0, rspCnt = 0;
  logic [7:0] rspLast = 8'h00;
  logic prevEn = 1'b0;
  logic [3:0] holdData = 4'h0;
  logic holdRs = 1'b0, holdRw = 1'b0, holdOe = 1'b0;
  logic [3:0] evData [64];
  logic evRs [64], evRw [64], evOe [64];
  int evCyc [64], evWidth [64];

  always #2.5 clk = ~clk;

  assign lcdDataIn = rdPhase ? rdLo : rdHi;

  lcd_nibble_bus #(.TICKS_PER_US(T)) u_lcd_nibble_bus (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqIsData(reqIsData), .reqIsRead(reqIsRead), .reqByte(reqByte),
    .rspValid(rspValid), .rspByte(rspByte), .initDone(initDone),
    .lcdRs(lcdRs), .lcdRw(lcdRw), .lcdEn(lcdEn), .lcdDataOut(lcdDataOut),
    .lcdDataOe(lcdDataOe), .lcdDataIn(lcdDataIn)
  );

  // bus monitor on the falling clock edge
  always @(negedge clk) begin
    if (!rstN) begin
      cyc = 0;
    end else begin
      cyc++;
      if (lcdEn) begin
        if (prevEn && (lcdDataOut != holdData || lcdRs != holdRs || lcdRw != holdRw))
          stabErr++;
        width = prevEn ? width + 1 : 1;
        holdData = lcdDataOut; holdRs = lcdRs; holdRw = lcdRw; holdOe = lcdDataOe;
      end
      if (prevEn && !lcdEn && nEv < 64) begin
        evData[nEv] = holdData; evRs[nEv] = holdRs; evRw[nEv] = holdRw;
        evOe[nEv] = holdOe; evCyc[nEv] = cyc; evWidth[nEv] = width;
        nEv++;
        if (holdRw) rdPhase = !rdPhase;
      end
      if (rspValid) begin rspCnt++; rspLast = rspByte; end
      prevEn = lcdEn;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic waitReady();
    for (int i = 0; i < 40000 && !reqReady; i++) step();
  endtask

  task automatic t_reset();
    for (int i = 0; i < 6; i++) begin
      step();
      chk(!reqReady && !initDone && !lcdEn, "R1 reset state", int'(reqReady), 0);
    end
  endtask

  task automatic t_init();
    int expNib [14] = '{3,3,3,2,2,8,0,8,0,1,0,6,0,12};
    int expGap [13] = '{4101,101,41,41,41,41,41,41,41,2001,41,41,41};
    // R10: a request while start-up runs must not reach the bus
    reqValid = 1'b1; reqIsData = 1'b1; reqByte = 8'h55;
    for (int i = 0; i < 10; i++) step();
    reqValid = 1'b0;
    for (int i = 0; i < 40000 && !initDone; i++) step();
    chk(initDone, "R1 initDone set", int'(initDone), 1);
    chk(nEv == 14, "R10 start-up transfer count", nEv, 14);
    chk(evCyc[0] >= 20000 && evCyc[0] <= 20002, "R1 power-up wait", evCyc[0], 20001);
    for (int i = 0; i < 14; i++) begin
      chk(int'(evData[i]) == expNib[i], "R2 start-up nibble", int'(evData[i]), expNib[i]);
      chk(!evRs[i] && !evRw[i], "R2 select/rw low", int'(evRs[i]), 0);
      chk(evWidth[i] == T, "R4 enable width", evWidth[i], T);
    end
    for (int i = 0; i < 13; i++)
      chk(evCyc[i+1] - evCyc[i] == expGap[i], "R3 start-up interval",
          evCyc[i+1] - evCyc[i], expGap[i]);
    chk(stabErr == 0, "R4 bus stable while enable high", stabErr, 0);
    waitReady();
    chk(reqReady, "R10 ready after start-up", int'(reqReady), 1);
  endtask

  task automatic t_xfer(input logic [7:0] b, input bit isData, input bit isRead,
                        input int expLow, input bit poke, input string req);
    int k, low, r0;
    waitReady();
    k = nEv; r0 = rspCnt;
    reqValid = 1'b1; reqIsData = isData; reqIsRead = isRead; reqByte = b;
    step();
    reqValid = 1'b0;
    low = reqReady ? 0 : 1;
    while (!reqReady && low < 5000) begin
      // R10: poke a request while busy
      reqValid = poke && low >= 100 && low < 110;
      reqByte  = 8'hAA;
      step();
      if (!reqReady) low++;
    end
    reqValid = 1'b0;
    chk(low == expLow, {req, " ready-low cycles"}, low, expLow);
    chk(nEv == k + 2, "R10 transfers per request", nEv - k, 2);
    chk(evCyc[k+1] - evCyc[k] == 41 * T, "R5 nibble interval",
        evCyc[k+1] - evCyc[k], 41 * T);
    chk(evWidth[k] == T && evWidth[k+1] == T, "R4 enable width", evWidth[k], T);
    chk(evRs[k] == isData && evRs[k+1] == isData, "R8 select line",
        int'(evRs[k]), int'(isData));
    chk(evRw[k] == isRead && evOe[k] == !isRead, "R9 rw/oe", int'(evRw[k]), int'(isRead));
    if (!isRead) begin
      chk(evData[k] == b[7:4], "R4 upper nibble first", int'(evData[k]), int'(b[7:4]));
      chk(evData[k+1] == b[3:0], "R4 lower nibble second", int'(evData[k+1]), int'(b[3:0]));
    end else begin
      chk(rspCnt == r0 + 1, "R9 one response", rspCnt - r0, 1);
      chk(rspLast == {rdHi, rdLo}, "R9 response byte", int'(rspLast), int'({rdHi, rdLo}));
    end
    chk(stabErr == 0, "R4 bus stable while enable high", stabErr, 0);
  endtask

  task automatic t_read(input bit isData, input logic [3:0] hi, input logic [3:0] lo);
    rdHi = hi; rdLo = lo; rdPhase = 1'b0;
    t_xfer(8'h00, isData, 1'b1, 82 * T, 1'b0, "R11 read");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_init();
    t_xfer(8'hA5, 1'b1, 1'b0, 82 * T, 1'b0, "R11 data write");
    t_xfer(8'h80, 1'b0, 1'b0, 82 * T, 1'b0, "R11 command write");
    t_xfer(8'h01, 1'b0, 1'b0, (2 + 40 + 2000) * T, 1'b1, "R6 clear");
    t_xfer(8'h02, 1'b0, 1'b0, (2 + 40 + 1600) * T, 1'b0, "R7 home");
    t_xfer(8'h01, 1'b1, 1'b0, 82 * T, 1'b0, "R6 data 0x01 has no long wait");
    t_read(1'b0, 4'h8, 4'h3);
    t_read(1'b1, 4'h4, 4'hC);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule